// File: doc/BRIEF.md
# Time-Slot Buffer Access Sequencer

This block decides, RAM cycle by RAM cycle, which access a shared upstream buffer RAM carries. Bytes arriving on the receive side are written into the buffer. Blocks of bytes bound for the transmit side are read out ahead of the time slots in which they are sent. The block keeps its own slot and sub-period count. A frame sync pulse restarts the count, and the count also wraps by itself at the end of each frame. Every time slot is split into eight RAM sub-periods. Writes are placed on some sub-periods and reads on others, so the two never meet.

The transmit side runs in one of three block modes. In each mode a different trigger slot starts a prefetch, at a different forward offset. Every prefetch is issued in two steps, and the block reports which transmit line group each step serves. One write sub-period at each transmit block boundary is blanked, because the RAM cannot accept a write there. A new mode is taken only at a frame sync. The data path, the serial shifting and the RAM array are outside this block.

Top module: `slot_buffer_sequencer`

## Requirements
- R1: The slot and sub-period count starts at slot 0, sub-period 0. The sub-period runs 0 to 7 and then moves on to the next slot. The slot wraps from SLOTS-1 to 0. A frame sync sampled high on a clock edge makes the count 0/0 after that edge. Every output is registered and shows the decode of the count one clock later.
- R2: Writes occur only on sub-periods 1 and 3. wr_addr = 2*slot + (1 when sub-period is 3, else 0). wr_addr is zero whenever wr_en is low.
- R3: In each mode, the sub-period 1 write is blanked in one slot position. Mode 0 blanks slots with slot mod 2 = 1. Mode 1 blanks slots with slot mod 4 = 2. Mode 2 blanks slots with slot mod 8 = 4.
- R4: Mode 0 (mode_sel 0) triggers on even slots s. Step 0 is read on sub-period 0 and step 1 on sub-period 4. Both steps use rd_addr = s+4.
- R5: Mode 1 (mode_sel 1) triggers on slots with s mod 4 = 1. Step 0 is read on sub-period 0 and step 1 on sub-period 4. Both steps use rd_addr = s+7, the first slot of block 4n+8.
- R6: Mode 2 (mode_sel 2) triggers on slots with s mod 8 = 3. Step 0 is read on sub-period 4 with rd_addr = s+13, the first half of block 8n+16. Step 1 is read on sub-period 7 with rd_addr = s+17, the second half.
- R7: rd_step is 0 on the first step and 1 on the second. In modes 0 and 1, rd_line is 0 on step 0 and 2 on step 1. In mode 2, rd_line is 0 on both steps. All read outputs are zero whenever rd_en is low.
- R8: Reads occur only on sub-periods 0, 4 and 7. rd_en and wr_en are never high in the same cycle.
- R9: mode_sel is sampled only when a frame sync is seen. The value 3 is ignored there, and the previous mode is kept.
- R10: While rst_n is low, all outputs are zero and the active mode is mode 0.
- R11: Read addresses are taken modulo SLOTS. SLOTS must be a multiple of 8 and at least 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RAM cycle clock, one sub-period per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync pulse that restarts the count |
| mode_sel | input | 2 | Requested transmit block mode |
| wr_en | output | 1 | Write strobe for receive data |
| wr_addr | output | SLOT_W+1 | Write byte address |
| rd_en | output | 1 | Read strobe for a transmit prefetch |
| rd_addr | output | SLOT_W | First slot of the block part being read |
| rd_line | output | 2 | First transmit line served by this step |
| rd_step | output | 1 | Step index within the block |

## Verification
Each mode runs for more than a full frame, so every trigger slot, every blanked slot and the wrapped prefetch addresses near the frame end all occur. SLOTS is set to 24, so wrap errors that a power-of-two size would hide become visible. The mode select is changed in the middle of a frame and is also set to the ignored value. These runs tell a correct sync-only mode update apart from an immediate one. A frame sync placed mid-slot separates a correct restart from free-running counting.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;
    typedef enum logic [1:0] {
        PM_PAIR = 2'd0,
        PM_QUAD = 2'd1,
        PM_OCT  = 2'd2
    } pcm_mode_e;

    localparam int SUB_N = 8;
    localparam int SUB_W = $clog2(SUB_N);

    // sub-period roles
    localparam logic [SUB_W-1:0] SP_RD_A = 3'd0;
    localparam logic [SUB_W-1:0] SP_WR_A = 3'd1;
    localparam logic [SUB_W-1:0] SP_WR_B = 3'd3;
    localparam logic [SUB_W-1:0] SP_RD_B = 3'd4;
    localparam logic [SUB_W-1:0] SP_RD_C = 3'd7;

    // forward distance from trigger slot to block start
    localparam int OFF_PAIR = 4;
    localparam int OFF_QUAD = 7;
    localparam int OFF_OCT  = 13;
    localparam int OCT_HALF = 4;

    localparam logic [1:0] LINE_LO = 2'd0;
    localparam logic [1:0] LINE_HI = 2'd2;
endpackage

// File: rtl/slot_seq_timebase.sv
module slot_seq_timebase
    import slot_seq_pkg::*;
#(
    parameter int SLOTS = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic [1:0]        mode_sel,
    output logic [SLOT_W-1:0] slot,
    output logic [SUB_W-1:0]  sub,
    output pcm_mode_e         mode
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [SUB_W-1:0]  sub;
        pcm_mode_e         mode;
    } tb_state_t;

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
    localparam logic [SUB_W-1:0]  LAST_SUB  = SUB_W'(SUB_N - 1);

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fsync) begin
            st_d.slot = '0;
            st_d.sub  = '0;
            if (mode_sel != 2'd3) begin
                st_d.mode = pcm_mode_e'(mode_sel);
            end
        end else if (st_q.sub == LAST_SUB) begin
            st_d.sub  = '0;
            st_d.slot = (st_q.slot == LAST_SLOT) ? '0 : st_q.slot + 1'b1;
        end else begin
            st_d.sub = st_q.sub + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.slot <= '0;
            st_q.sub  <= '0;
            st_q.mode <= PM_PAIR;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot = st_q.slot;
    assign sub  = st_q.sub;
    assign mode = st_q.mode;
endmodule

// File: rtl/slot_seq_wr_sched.sv
module slot_seq_wr_sched
    import slot_seq_pkg::*;
#(
    parameter int SLOTS = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [SUB_W-1:0]  sub,
    input  pcm_mode_e         mode,
    output logic              wr_en,
    output logic [SLOT_W:0]   wr_addr
);
    logic wr_slot_ok;
    logic boundary;

    always_comb begin
        wr_slot_ok = (sub == SP_WR_A) || (sub == SP_WR_B);
        unique case (mode)
            PM_PAIR: boundary = slot[0];
            PM_QUAD: boundary = (slot[1:0] == 2'd2);
            PM_OCT:  boundary = (slot[2:0] == 3'd4);
            default: boundary = 1'b0;
        endcase
        wr_en   = wr_slot_ok && !((sub == SP_WR_A) && boundary);
        wr_addr = wr_en ? {slot, (sub == SP_WR_B)} : '0;
    end
endmodule

// File: rtl/slot_seq_rd_sched.sv
module slot_seq_rd_sched
    import slot_seq_pkg::*;
#(
    parameter int SLOTS = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [SUB_W-1:0]  sub,
    input  pcm_mode_e         mode,
    output logic              rd_en,
    output logic [SLOT_W-1:0] rd_addr,
    output logic [1:0]        rd_line,
    output logic              rd_step
);
    localparam int OFF_W = 5;

    logic              hit;
    logic [OFF_W-1:0]  off;
    logic [SLOT_W:0]   sum;

    always_comb begin
        hit     = 1'b0;
        off     = '0;
        rd_line = LINE_LO;
        rd_step = 1'b0;
        unique case (mode)
            PM_PAIR: begin
                if (!slot[0] && (sub == SP_RD_A || sub == SP_RD_B)) begin
                    hit     = 1'b1;
                    off     = OFF_W'(OFF_PAIR);
                    rd_step = (sub == SP_RD_B);
                    rd_line = (sub == SP_RD_B) ? LINE_HI : LINE_LO;
                end
            end
            PM_QUAD: begin
                if ((slot[1:0] == 2'd1) && (sub == SP_RD_A || sub == SP_RD_B)) begin
                    hit     = 1'b1;
                    off     = OFF_W'(OFF_QUAD);
                    rd_step = (sub == SP_RD_B);
                    rd_line = (sub == SP_RD_B) ? LINE_HI : LINE_LO;
                end
            end
            PM_OCT: begin
                if ((slot[2:0] == 3'd3) && (sub == SP_RD_B || sub == SP_RD_C)) begin
                    hit     = 1'b1;
                    rd_step = (sub == SP_RD_C);
                    off     = (sub == SP_RD_C) ? OFF_W'(OFF_OCT + OCT_HALF)
                                               : OFF_W'(OFF_OCT);
                end
            end
            default: hit = 1'b0;
        endcase

        sum = {1'b0, slot} + (SLOT_W+1)'(off);
        if (sum >= (SLOT_W+1)'(SLOTS)) begin
            sum = sum - (SLOT_W+1)'(SLOTS);
        end

        rd_en = hit;
        if (!hit) begin
            rd_addr = '0;
            rd_line = '0;
            rd_step = 1'b0;
        end else begin
            rd_addr = sum[SLOT_W-1:0];
        end
    end
endmodule

// File: rtl/slot_buffer_sequencer.sv
module slot_buffer_sequencer
    import slot_seq_pkg::*;
#(
    parameter int SLOTS = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic [1:0]        mode_sel,
    output logic              wr_en,
    output logic [SLOT_W:0]   wr_addr,
    output logic              rd_en,
    output logic [SLOT_W-1:0] rd_addr,
    output logic [1:0]        rd_line,
    output logic              rd_step
);
    typedef struct packed {
        logic              wr_en;
        logic [SLOT_W:0]   wr_addr;
        logic              rd_en;
        logic [SLOT_W-1:0] rd_addr;
        logic [1:0]        rd_line;
        logic              rd_step;
    } acc_t;

    logic [SLOT_W-1:0] cur_slot;
    logic [SUB_W-1:0]  cur_sub;
    pcm_mode_e         cur_mode;

    logic              w_en;
    logic [SLOT_W:0]   w_addr;
    logic              r_en;
    logic [SLOT_W-1:0] r_addr;
    logic [1:0]        r_line;
    logic              r_step;

    acc_t acc_d, acc_q;

    slot_seq_timebase #(.SLOTS(SLOTS)) timebase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .mode_sel (mode_sel),
        .slot     (cur_slot),
        .sub      (cur_sub),
        .mode     (cur_mode)
    );

    slot_seq_wr_sched #(.SLOTS(SLOTS)) wr_sched_i (
        .slot    (cur_slot),
        .sub     (cur_sub),
        .mode    (cur_mode),
        .wr_en   (w_en),
        .wr_addr (w_addr)
    );

    slot_seq_rd_sched #(.SLOTS(SLOTS)) rd_sched_i (
        .slot    (cur_slot),
        .sub     (cur_sub),
        .mode    (cur_mode),
        .rd_en   (r_en),
        .rd_addr (r_addr),
        .rd_line (r_line),
        .rd_step (r_step)
    );

    always_comb begin
        acc_d         = '0;
        acc_d.wr_en   = w_en;
        acc_d.wr_addr = w_addr;
        acc_d.rd_en   = r_en;
        acc_d.rd_addr = r_addr;
        acc_d.rd_line = r_line;
        acc_d.rd_step = r_step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign wr_en   = acc_q.wr_en;
    assign wr_addr = acc_q.wr_addr;
    assign rd_en   = acc_q.rd_en;
    assign rd_addr = acc_q.rd_addr;
    assign rd_line = acc_q.rd_line;
    assign rd_step = acc_q.rd_step;
endmodule

// File: rtl/slot_seq_checker.sv
module slot_seq_checker #(
    parameter int SLOTS = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SLOT_W:0]   wr_addr,
    input logic              rd_en,
    input logic [SLOT_W-1:0] rd_addr,
    input logic [1:0]        rd_line,
    input logic              rd_step
);
    assert_rw_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    assert_wr_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    assert_wr_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr[SLOT_W:1] < SLOT_W'(SLOTS)));

    assert_rd_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr < SLOT_W'(SLOTS)));

    assert_line_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_step && rd_line == 2'd2) |->
            ($past(rd_en, 4) && !$past(rd_step, 4) && $past(rd_addr, 4) == rd_addr));

    assert_idle_in_reset_R10: assert property (@(posedge clk)
        !rst_n |-> (!rd_en && !wr_en));
endmodule

bind slot_buffer_sequencer slot_seq_checker #(.SLOTS(SLOTS)) checker_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_line (rd_line),
    .rd_step (rd_step)
);

// File: tb/slot_buffer_sequencer_tb.sv
module slot_buffer_sequencer_tb_top;
    localparam int NSLOT  = 24;
    localparam int SLOT_W = $clog2(NSLOT);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fsync = 1'b0;
    logic [1:0]        mode_sel = 2'd0;
    logic              wr_en;
    logic [SLOT_W:0]   wr_addr;
    logic              rd_en;
    logic [SLOT_W-1:0] rd_addr;
    logic [1:0]        rd_line;
    logic              rd_step;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    slot_buffer_sequencer #(.SLOTS(NSLOT)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .mode_sel (mode_sel),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_line  (rd_line),
        .rd_step  (rd_step)
    );

    typedef struct {
        bit wen; int waddr; bit ren; int raddr; int line; bit step;
        int wtag; int rtag;
    } exp_t;

    exp_t sb_q[$];

    // reference count kept by the bench (R1, R9, R10)
    int m_slot = 0;
    int m_sub  = 0;
    int m_mode = 0;

    function automatic exp_t predict(int s, int p, int m);
        exp_t e;
        int start;
        e = '{default: 0};
        e.wtag = 2;
        e.rtag = 4 + m;
        // write side, R2 / R3
        if (p == 1 || p == 3) begin
            if (p == 1 && ((m == 0 && s % 2 == 1) || (m == 1 && s % 4 == 2) ||
                           (m == 2 && s % 8 == 4))) begin
                e.wtag = 3;
            end else begin
                e.wen   = 1'b1;
                e.waddr = 2 * s + ((p == 3) ? 1 : 0);
            end
        end
        // read side, R4 / R5 / R6 / R7
        start = -1;
        if (m == 0 && s % 2 == 0 && (p == 0 || p == 4)) begin
            start = s + 4; e.step = (p == 4); e.line = (p == 4) ? 2 : 0;
        end else if (m == 1 && s % 4 == 1 && (p == 0 || p == 4)) begin
            start = (s - 1) + 8; e.step = (p == 4); e.line = (p == 4) ? 2 : 0;
        end else if (m == 2 && s % 8 == 3 && (p == 4 || p == 7)) begin
            start = (s - 3) + 16 + ((p == 7) ? 4 : 0); e.step = (p == 7); e.line = 0;
        end
        if (start >= 0) begin
            e.ren = 1'b1;
            if (start >= NSLOT) begin
                start  = start - NSLOT;
                e.rtag = 11;
            end
            e.raddr = start;
        end
        return e;
    endfunction

    task automatic push_expected();
        exp_t e;
        if (!rst_n) begin
            e = '{default: 0};
            e.wtag = 10; e.rtag = 10;
            m_slot = 0; m_sub = 0; m_mode = 0;
        end else begin
            e = predict(m_slot, m_sub, m_mode);
            if (fsync) begin
                m_slot = 0; m_sub = 0;
                if (mode_sel != 2'd3) m_mode = int'(mode_sel);
            end else if (m_sub == 7) begin
                m_sub = 0;
                m_slot = (m_slot == NSLOT - 1) ? 0 : m_slot + 1;
            end else begin
                m_sub = m_sub + 1;
            end
        end
        sb_q.push_back(e);
    endtask

    always @(posedge clk) push_expected();

    // monitor: pops one expected item per cycle
    always @(negedge clk) begin
        if (!finished && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (wr_en !== e.wen || int'(wr_addr) != e.waddr || $isunknown(wr_addr)) begin
                n_bad++;
                $display("FAIL R%0d write: got en=%0b addr=%0d expected en=%0b addr=%0d",
                         e.wtag, wr_en, wr_addr, e.wen, e.waddr);
            end
            if (rd_en !== e.ren || int'(rd_addr) != e.raddr || $isunknown(rd_addr)) begin
                n_bad++;
                $display("FAIL R%0d read: got en=%0b addr=%0d expected en=%0b addr=%0d",
                         e.rtag, rd_en, rd_addr, e.ren, e.raddr);
            end
            if (int'(rd_line) != e.line || rd_step !== e.step) begin
                n_bad++;
                $display("FAIL R7 line/step: got line=%0d step=%0b expected line=%0d step=%0b",
                         rd_line, rd_step, e.line, e.step);
            end
            n_cmp++;
            if (rd_en === 1'b1 && wr_en === 1'b1) begin
                n_bad++;
                $display("FAIL R8 overlap: got rd=1 wr=1 expected at most one");
            end
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sync_pulse();
        @(negedge clk);
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
    endtask

    initial begin
        // R10: outputs idle while reset is held
        run(3);
        n_cmp++;
        if (wr_en !== 1'b0 || rd_en !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset: got wr=%0b rd=%0b expected 0 0", wr_en, rd_en);
        end
        rst_n = 1'b1;
        // mode 0 with free-running wrap, R1 and R11
        run(2 * NSLOT * 8 + 5);
        // R9: request mode 1 mid-frame, must stay mode 0 until sync
        mode_sel = 2'd1;
        run(100);
        sync_pulse();
        run(2 * NSLOT * 8);
        // mode 2, wrapped prefetch addresses (R6, R11)
        mode_sel = 2'd2;
        sync_pulse();
        run(2 * NSLOT * 8);
        // R9: value 3 ignored at sync, mode 2 kept
        mode_sel = 2'd3;
        sync_pulse();
        run(NSLOT * 8 + 11);
        // R1: sync in the middle of a slot restarts the count
        mode_sel = 2'd0;
        run(37);
        sync_pulse();
        run(NSLOT * 8);
        mode_sel = 2'd1;
        run(5);
        sync_pulse();
        run(NSLOT * 8 + 3);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got no completion expected end of stimulus");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule